// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of general-purpose 32-bit event counters whose only event source is a software increment. A dedicated increment port carries a bitmask with one bit per counter. A selected counter advances by one in that cycle when three conditions hold: the bank-wide enable is set, the counter's own enable bit is set, and its type register holds the software-increment event code. Counters advance together, in the same clock cycle as the increment request.

Two neighbouring counters can act as one 64-bit counter. An even counter is the low half and the next odd counter is the high half. The pair is joined when the odd counter's type register holds the chain code. When the low half wraps, the carry goes into the high half, and only the high half reports overflow. A sticky overflow-status register records every wrap that is reported. It has separate write-one-to-set and write-one-to-clear addresses.

A single register port gives read and write access to the counters, the type registers, the enables and the overflow status.

Top module: `evtctr_bank`

## Requirements
- R1: While the bank-wide enable (address 16, bit 0) is 0, an increment request changes no counter.
- R2: The increment mask is ANDed with the counter-enable register (address 17, bit i for counter i), so a counter whose enable bit is 0 does not advance.
- R3: A selected counter advances only if its type register holds the software-increment code 0x000. A selected counter with any other type is skipped.
- R4: Each counter is 32 bits wide, advances by exactly one per increment, and wraps from 0xFFFFFFFF to 0.
- R5: When a counter that is not the low half of a chained pair wraps, its own overflow-status bit is set.
- R6: When even counter i wraps and counter i+1 holds the chain code 0x01E, counter i+1 advances by one in the same cycle and overflow bit i is not set. The carry ignores the enable bit of counter i+1. An odd counter followed by an even counter never forms a chained pair.
- R7: When the high half of a chained pair wraps, overflow bit i+1 is set.
- R8: Overflow bits are sticky. Writing 1s to address 18 clears the matching bits, and writing 1s to address 19 sets them. Bits written as 0 are left unchanged.
- R9: If a counter wraps in the same cycle as a clear write that targets its overflow bit, the bit ends up set.
- R10: If a register write to a counter falls in the same cycle as an increment of that counter, the written value is stored and the increment is dropped.
- R11: Address map: counter i is at address i. Type i is at address 8+i and reads back zero-extended. The bank enable is at 16 and the counter-enable register is at 17. Addresses 18 and 19 both read the overflow status.
- R12: After reset, every counter, type, enable and overflow bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Combinational read data |
| inc_valid | input | 1 | Software-increment request |
| inc_mask | input | N_CTR (6) | Counters selected for increment |

## Verification
Two kinds of same-cycle conflict are provoked: a register write to a counter together with an increment of that counter, and a clear write to an overflow bit together with a wrap that sets the same bit. In each case the bench drives both the write port and the increment port in one cycle, then reads back the counter value and the overflow status. For the first conflict it expects the written value. For the second it expects the overflow bit to be set, while a second bit cleared by the same write drops. A chained carry is also made to coincide with a wrap of the high half, which checks that only the odd bit of the overflow status rises.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;

   localparam int ADDR_W = 5;
   localparam int IDX_W  = 3;
   localparam int MAX_CTR = 1 << IDX_W;

   typedef enum logic [1:0] {
      RK_CNT  = 2'd0,
      RK_TYP  = 2'd1,
      RK_CTL  = 2'd2,
      RK_NONE = 2'd3
   } reg_kind_e;

   localparam logic [IDX_W-1:0] CTL_GLB   = 3'd0;
   localparam logic [IDX_W-1:0] CTL_ENA   = 3'd1;
   localparam logic [IDX_W-1:0] CTL_OVCLR = 3'd2;
   localparam logic [IDX_W-1:0] CTL_OVSET = 3'd3;

   localparam logic [ADDR_W-1:0] ADDR_OVCLR = {RK_CTL, CTL_OVCLR};

endpackage

// File: rtl/evtctr_regdec.sv
module evtctr_regdec
   import evtctr_pkg::*;
#(
   parameter int N_CTR = 6
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [N_CTR-1:0]  cnt_we,
   output logic [N_CTR-1:0]  typ_we,
   output logic              glb_we,
   output logic              ena_we,
   output logic              ovclr_we,
   output logic              ovset_we
);

   reg_kind_e        kind;
   logic [IDX_W-1:0] idx;

   assign kind = reg_kind_e'(wr_addr[ADDR_W-1 -: 2]);
   assign idx  = wr_addr[IDX_W-1:0];

   for (genvar i = 0; i < N_CTR; i++) begin : g_we
      assign cnt_we[i] = wr_en && (kind == RK_CNT) && (idx == IDX_W'(i));
      assign typ_we[i] = wr_en && (kind == RK_TYP) && (idx == IDX_W'(i));
   end

   assign glb_we   = wr_en && (kind == RK_CTL) && (idx == CTL_GLB);
   assign ena_we   = wr_en && (kind == RK_CTL) && (idx == CTL_ENA);
   assign ovclr_we = wr_en && (kind == RK_CTL) && (idx == CTL_OVCLR);
   assign ovset_we = wr_en && (kind == RK_CTL) && (idx == CTL_OVSET);

endmodule

// File: rtl/evtctr_incsel.sv
module evtctr_incsel #(
   parameter int              N_CTR      = 6,
   parameter int              EVT_W      = 10,
   parameter logic [EVT_W-1:0] SWINC_CODE = '0,
   parameter logic [EVT_W-1:0] CHAIN_CODE = 10'h01E
) (
   input  logic                        glb_en,
   input  logic [N_CTR-1:0]            ena,
   input  logic                        inc_valid,
   input  logic [N_CTR-1:0]            inc_mask,
   input  logic [N_CTR-1:0][EVT_W-1:0] typ,
   input  logic [N_CTR-1:0]            at_max,
   input  logic [N_CTR-1:0]            cnt_we,
   output logic [N_CTR-1:0]            adv,
   output logic [N_CTR-1:0]            ovf_hit
);

   logic [N_CTR-1:0] sel;
   logic [N_CTR-1:0] own;
   logic [N_CTR-1:0] carry;
   logic [N_CTR-1:0] is_lo;

   for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
      assign sel[i] = glb_en && inc_valid && inc_mask[i] && ena[i]
                      && (typ[i] == SWINC_CODE);
      // a register write on the same counter wins over the increment
      assign own[i] = sel[i] && !cnt_we[i];

      if (i % 2 == 1) begin : g_hi
         assign carry[i] = own[i-1] && at_max[i-1] && (typ[i] == CHAIN_CODE);
         assign is_lo[i] = 1'b0;
      end else if (i + 1 < N_CTR) begin : g_lo
         assign carry[i] = 1'b0;
         assign is_lo[i] = (typ[i+1] == CHAIN_CODE);
      end else begin : g_last
         assign carry[i] = 1'b0;
         assign is_lo[i] = 1'b0;
      end

      assign adv[i]     = (own[i] || carry[i]) && !cnt_we[i];
      assign ovf_hit[i] = adv[i] && at_max[i] && !is_lo[i];
   end

endmodule

// File: rtl/evtctr_slice.sv
module evtctr_slice #(
   parameter int CTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CTR_W-1:0] ld_val,
   input  logic             adv,
   output logic [CTR_W-1:0] cnt_q,
   output logic             at_max
);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld)     cnt_q <= ld_val;
      else if (adv)    cnt_q <= cnt_q + CTR_W'(1);
   end

   assign at_max = &cnt_q;

endmodule

// File: rtl/evtctr_bank.sv
module evtctr_bank
   import evtctr_pkg::*;
#(
   parameter int               N_CTR      = 6,
   parameter int               CTR_W      = 32,
   parameter int               EVT_W      = 10,
   parameter logic [EVT_W-1:0] SWINC_CODE = 10'h000,
   parameter logic [EVT_W-1:0] CHAIN_CODE = 10'h01E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [4:0]        rd_addr,
   output logic [31:0]       rd_data,
   input  logic              inc_valid,
   input  logic [N_CTR-1:0]  inc_mask
);

   if (N_CTR < 1 || N_CTR > MAX_CTR) begin : g_bad_n
      $error("evtctr_bank: N_CTR out of range");
   end
   if (CTR_W != 32) begin : g_bad_w
      $error("evtctr_bank: register port is 32 bits wide");
   end
   if (EVT_W > CTR_W) begin : g_bad_e
      $error("evtctr_bank: event field wider than data path");
   end
   if (SWINC_CODE == CHAIN_CODE) begin : g_bad_code
      $error("evtctr_bank: event codes must differ");
   end

   logic [N_CTR-1:0][CTR_W-1:0] cnt_q;
   logic [N_CTR-1:0][EVT_W-1:0] typ_q;
   logic [N_CTR-1:0]            ena_q;
   logic [N_CTR-1:0]            ovf_q;
   logic                        glb_en_q;

   logic [N_CTR-1:0] cnt_we, typ_we, at_max, adv, ovf_hit;
   logic             glb_we, ena_we, ovclr_we, ovset_we;
   logic [N_CTR-1:0] ov_clr_bits, ov_set_bits;

   evtctr_regdec #(.N_CTR(N_CTR)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .cnt_we   (cnt_we),
      .typ_we   (typ_we),
      .glb_we   (glb_we),
      .ena_we   (ena_we),
      .ovclr_we (ovclr_we),
      .ovset_we (ovset_we)
   );

   evtctr_incsel #(
      .N_CTR      (N_CTR),
      .EVT_W      (EVT_W),
      .SWINC_CODE (SWINC_CODE),
      .CHAIN_CODE (CHAIN_CODE)
   ) u_sel (
      .glb_en    (glb_en_q),
      .ena       (ena_q),
      .inc_valid (inc_valid),
      .inc_mask  (inc_mask),
      .typ       (typ_q),
      .at_max    (at_max),
      .cnt_we    (cnt_we),
      .adv       (adv),
      .ovf_hit   (ovf_hit)
   );

   for (genvar i = 0; i < N_CTR; i++) begin : g_slice
      evtctr_slice #(.CTR_W(CTR_W)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (cnt_we[i]),
         .ld_val (wr_data),
         .adv    (adv[i]),
         .cnt_q  (cnt_q[i]),
         .at_max (at_max[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)         typ_q[i] <= '0;
         else if (typ_we[i]) typ_q[i] <= wr_data[EVT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_en_q <= 1'b0;
         ena_q    <= '0;
      end else begin
         if (glb_we) glb_en_q <= wr_data[0];
         if (ena_we) ena_q    <= wr_data[N_CTR-1:0];
      end
   end

   assign ov_clr_bits = ovclr_we ? wr_data[N_CTR-1:0] : '0;
   assign ov_set_bits = ovset_we ? wr_data[N_CTR-1:0] : '0;

   // hardware wrap is OR-ed after the clear so it is never lost
   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= (ovf_q & ~ov_clr_bits) | ov_set_bits | ovf_hit;
   end

   reg_kind_e        rd_kind;
   logic [IDX_W-1:0] rd_idx;

   assign rd_kind = reg_kind_e'(rd_addr[ADDR_W-1 -: 2]);
   assign rd_idx  = rd_addr[IDX_W-1:0];

   always_comb begin
      rd_data = '0;
      unique case (rd_kind)
         RK_CNT: begin
            for (int i = 0; i < N_CTR; i++)
               if (rd_idx == IDX_W'(i)) rd_data = cnt_q[i];
         end
         RK_TYP: begin
            for (int i = 0; i < N_CTR; i++)
               if (rd_idx == IDX_W'(i)) rd_data = CTR_W'(typ_q[i]);
         end
         RK_CTL: begin
            if (rd_idx == CTL_GLB)      rd_data = CTR_W'(glb_en_q);
            else if (rd_idx == CTL_ENA) rd_data = CTR_W'(ena_q);
            else if (rd_idx == CTL_OVCLR || rd_idx == CTL_OVSET)
                                        rd_data = CTR_W'(ovf_q);
         end
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/evtctr_bank_chk.sv
module evtctr_bank_chk
   import evtctr_pkg::*;
#(
   parameter int               N_CTR      = 6,
   parameter int               CTR_W      = 32,
   parameter int               EVT_W      = 10,
   parameter logic [EVT_W-1:0] CHAIN_CODE = 10'h01E
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [ADDR_W-1:0]           wr_addr,
   input logic                        glb_en,
   input logic [N_CTR-1:0][CTR_W-1:0] cnt,
   input logic [N_CTR-1:0][EVT_W-1:0] typ,
   input logic [N_CTR-1:0]            ovf
);

   // R1: bank disabled and no register write, so the counters hold
   a_r1_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !wr_en) |=> $stable(cnt));

   // R8: without a clear write, no overflow bit falls
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_OVCLR) |=> ((ovf & $past(ovf)) == $past(ovf)));

   for (genvar i = 0; i < N_CTR; i++) begin : g_step
      // R4: a counter moves by one step at most when nothing is written
      a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + CTR_W'(1)));
   end

   for (genvar i = 0; i + 1 < N_CTR; i += 2) begin : g_pair
      // R6: the low half of a chained pair never raises its own overflow bit
      a_r6_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[i+1] == CHAIN_CODE && !wr_en) |=> !$rose(ovf[i]));
   end

endmodule

bind evtctr_bank evtctr_bank_chk #(
   .N_CTR      (N_CTR),
   .CTR_W      (CTR_W),
   .EVT_W      (EVT_W),
   .CHAIN_CODE (CHAIN_CODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .glb_en  (glb_en_q),
   .cnt     (cnt_q),
   .typ     (typ_q),
   .ovf     (ovf_q)
);

// File: tb/evtctr_bank_tb.sv
`timescale 1ns/1ps
module evtctr_bank_tb;

   localparam int N = 6;
   localparam logic [31:0] SWINC = 32'h000;
   localparam logic [31:0] CHAIN = 32'h01E;
   localparam logic [31:0] OTHER = 32'h011;
   localparam logic [4:0] A_GLB = 5'd16, A_ENA = 5'd17, A_CLR = 5'd18, A_SET = 5'd19;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        inc_valid = 1'b0;
   logic [N-1:0] inc_mask = '0;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [4:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #10 clk = ~clk;

   evtctr_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .inc_valid (inc_valid),
      .inc_mask  (inc_mask)
   );

   // monitor: compares each expected item against the read port
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_cmp++;
         if (rd_data !== it.exp) begin
            n_bad++;
            $display("FAIL %s addr %0d actual %h expected %h", it.tag, it.addr, rd_data, it.exp);
         end
      end
   end

   task automatic idle_strobes();
      wr_en = 1'b0;
      inc_valid = 1'b0;
      inc_mask = '0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      idle_strobes();
      wr_en = 1'b1; wr_addr = a; wr_data = d;
   endtask

   task automatic inc(input logic [N-1:0] m);
      @(posedge clk); #1;
      idle_strobes();
      inc_valid = 1'b1; inc_mask = m;
   endtask

   task automatic wr_inc(input logic [4:0] a, input logic [31:0] d, input logic [N-1:0] m);
      @(posedge clk); #1;
      idle_strobes();
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      inc_valid = 1'b1; inc_mask = m;
   endtask

   task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      idle_strobes();
      rd_addr = a;
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(20 * 50000);
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: reset state
      expect_rd(5'd0, 32'h0, "R12 counter0");
      expect_rd(5'd9, 32'h0, "R12 type1");
      expect_rd(A_GLB, 32'h0, "R12 bank enable");
      expect_rd(A_CLR, 32'h0, "R12 overflow");

      wr(5'd8,  SWINC);
      wr(5'd9,  CHAIN);
      wr(5'd10, SWINC);
      wr(5'd11, SWINC);
      wr(5'd12, OTHER);
      wr(5'd13, SWINC);
      wr(A_ENA, 32'h37);

      // R1: bank disabled
      inc(6'h3F);
      expect_rd(5'd0, 32'h0, "R1 counter0 frozen");
      expect_rd(5'd5, 32'h0, "R1 counter5 frozen");

      wr(A_GLB, 32'h1);
      inc(6'h3F);
      expect_rd(5'd0, 32'h1, "R4 counter0 step");
      expect_rd(5'd1, 32'h0, "R6 chained high no carry");
      expect_rd(5'd2, 32'h1, "R4 counter2 step");
      expect_rd(5'd3, 32'h0, "R2 disabled counter3");
      expect_rd(5'd4, 32'h0, "R3 wrong type counter4");
      expect_rd(5'd5, 32'h1, "R4 counter5 step");

      // R5: unchained wrap, pair 2/3 not chained
      wr(5'd2, 32'hFFFF_FFFF);
      inc(6'h04);
      expect_rd(5'd2, 32'h0, "R4 counter2 wrap");
      expect_rd(5'd3, 32'h0, "R6 unchained no carry");
      expect_rd(A_CLR, 32'h4, "R5 overflow bit2");

      // R6: chained carry, high half disabled
      wr(A_ENA, 32'h35);
      wr(5'd0, 32'hFFFF_FFFF);
      wr(5'd1, 32'h5);
      inc(6'h01);
      expect_rd(5'd0, 32'h0, "R6 low wraps");
      expect_rd(5'd1, 32'h6, "R6 high gets carry");
      expect_rd(A_CLR, 32'h4, "R6 no low overflow bit");

      // R7: high half wraps
      wr(5'd0, 32'hFFFF_FFFF);
      wr(5'd1, 32'hFFFF_FFFF);
      inc(6'h01);
      expect_rd(5'd0, 32'h0, "R7 low wraps");
      expect_rd(5'd1, 32'h0, "R7 high wraps");
      expect_rd(A_SET, 32'h6, "R7 overflow bit1");

      // R8: write-one clear and set
      wr(A_CLR, 32'h2);
      expect_rd(A_CLR, 32'h4, "R8 clear bit1");
      wr(A_SET, 32'h1);
      expect_rd(A_SET, 32'h5, "R8 set bit0");

      // R10: write beats increment on counter5
      wr_inc(5'd5, 32'd100, 6'h20);
      expect_rd(5'd5, 32'd100, "R10 write priority");

      // R9: wrap beats simultaneous clear
      wr(A_SET, 32'h20);
      wr(5'd5, 32'hFFFF_FFFF);
      wr_inc(A_CLR, 32'h21, 6'h20);
      expect_rd(5'd5, 32'h0, "R9 counter5 wraps");
      expect_rd(A_CLR, 32'h24, "R9 set wins bit5, bit0 clears");

      // R11: readback
      expect_rd(5'd9,  CHAIN, "R11 type1 readback");
      expect_rd(5'd12, OTHER, "R11 type4 readback");
      expect_rd(A_ENA, 32'h35, "R11 enable readback");
      expect_rd(A_GLB, 32'h1, "R11 bank enable readback");

      repeat (3) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R11 scoreboard actual %0d pending expected 0", sb_q.size());
      end
      summary();
      $finish;
   end

endmodule